// File: doc/BRIEF.md
# Link Self-Test Control and Status Unit

This unit runs a built-in self-test session on the receive side of a serial link. It picks where the test configuration comes from: two strap pins, which are used after reset, or a small control register. It turns the chosen code into an encoded clock-source selection. For register control, that selection also depends on the link data mode. While a session is active it counts the frames that carry errors, keeps that count readable, and drives a status pin.

The status pin gives one half-period low pulse for each errored frame, so an outside tester can count errored frames. Back-to-back errored frames still give separate pulses. When a session ends, the pin holds the pass/fail verdict for exactly one pixel period. The unit runs on a clock at twice the pixel rate. A phase flop splits each pixel period into a first half and a second half. All inputs are sampled once per pixel period, on the edge that ends the second half. The status pin comes straight from a flop, so it has no glitches.

Top module: `bist_ctrl_unit`

## Requirements
- R1: After reset: `pass_o` is 1, `err_cnt_o` is 0 and `rsvd_o` is 0. Configuration comes from the straps.
- R2: With strap control, `clk_sel_o` follows the strap code: 00 gives 0 (pixel clock), 01 gives 3 (oscillator ~50 MHz), 10 gives 5 (oscillator ~25 MHz) and 11 gives 0. The data mode has no effect.
- R3: The register is written when `reg_we_i` is 1. Bit 0 set to 1 selects register control and bit 0 set to 0 returns control to the straps. Bits [2:1] hold the code, and code 00 gives 0. Code 01 gives a fast rate and code 10 gives half of it. By data mode (00 = 10-bit, 01 = 12-bit high-frequency, 10 or 11 = 12-bit low-frequency), code 01 gives 1, 2 or 3 (100, 75, 50 MHz) and code 10 gives 3, 4 or 5 (50, 37.5, 25 MHz). The new selection is visible from the cycle after the write.
- R4: Register code 11 selects the pixel clock (0) and sets `rsvd_o`, which then stays set until reset.
- R5: Pixel periods are pairs of clock cycles counted from the release of reset. Inputs are sampled on the second cycle of each pair. An errored frame in pixel period N gives `pass_o` = 1 in the first half of period N+1 and `pass_o` = 0 in its second half. Otherwise `pass_o` stays 1.
- R6: A frame counts as errored only when `frame_vld_i` and `frame_err_i` are both 1 while `run_i` is 1 and a session is already active. A rise of `run_i` starts a session, and the frame sampled in that period is not counted.
- R7: The 8-bit error-frame count saturates at 255.
- R8: A fall of `run_i` in period N ends the session. For the whole of period N+1, `pass_o` is 1 if the count was zero and 0 otherwise.
- R9: The count is cleared in the first period of a new session. Otherwise it keeps its value after the session ends, until the next session starts or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock (two cycles per pixel period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Session enable; a rise starts and a fall ends a session |
| frame_vld_i | input | 1 | A frame completes in this pixel period |
| frame_err_i | input | 1 | The completing frame had at least one error |
| strap_i | input | 2 | Strap-pin test configuration code |
| mode_i | input | 2 | Link data mode |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 3 | Control write data: [0] source, [2:1] code |
| pass_o | output | 1 | Status pin: error pulses and final verdict |
| clk_sel_o | output | 3 | Encoded clock-source/frequency selection |
| err_cnt_o | output | 8 | Errored-frame count of the latest session |
| rsvd_o | output | 1 | Sticky flag: reserved register code was written |

## Verification
A wrong phase flop moves every error pulse into the first half of the period. The pin then reads low one clock cycle early, which shows on the first errored frame. A session flag that is off by one counts the start frame or misses the last one. That shows in `err_cnt_o` one pixel period later and in the verdict level one period after the session ends. Faults in the count or the decode appear at the ports in the cycle after the sampling edge or register write: a count that wraps past 255, a verdict that uses the count after an extra update, or a wrong rate entry in the decode.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [2:0] {
    SEL_PCLK    = 3'd0,
    SEL_OSC100  = 3'd1,
    SEL_OSC75   = 3'd2,
    SEL_OSC50   = 3'd3,
    SEL_OSC37P5 = 3'd4,
    SEL_OSC25   = 3'd5
  } clk_sel_e;

  typedef enum logic [1:0] {
    MODE_10B    = 2'd0,
    MODE_12B_HF = 2'd1,
    MODE_12B_LF = 2'd2,
    MODE_SPARE  = 2'd3
  } data_mode_e;

  // Strap codes: fixed oscillator rates, independent of the data mode.
  function automatic clk_sel_e strap_decode(input logic [1:0] code);
    case (code)
      2'b01:   strap_decode = SEL_OSC50;
      2'b10:   strap_decode = SEL_OSC25;
      default: strap_decode = SEL_PCLK;
    endcase
  endfunction

  // Fast rate for register code 01; code 10 picks the next half step.
  function automatic clk_sel_e fast_rate(input logic [1:0] mode);
    case (mode)
      MODE_10B:    fast_rate = SEL_OSC100;
      MODE_12B_HF: fast_rate = SEL_OSC75;
      default:     fast_rate = SEL_OSC50;
    endcase
  endfunction

  function automatic clk_sel_e half_rate(input logic [1:0] mode);
    case (mode)
      MODE_10B:    half_rate = SEL_OSC50;
      MODE_12B_HF: half_rate = SEL_OSC37P5;
      default:     half_rate = SEL_OSC25;
    endcase
  endfunction

  function automatic clk_sel_e reg_decode(input logic [1:0] code,
                                          input logic [1:0] mode);
    case (code)
      2'b01:   reg_decode = fast_rate(mode);
      2'b10:   reg_decode = half_rate(mode);
      default: reg_decode = SEL_PCLK;
    endcase
  endfunction

  function automatic logic is_reserved(input logic [1:0] code);
    is_reserved = (code == 2'b11);
  endfunction

endpackage

// File: rtl/bist_cfg.sv
module bist_cfg
  import bist_pkg::*;
#(
  parameter int CTRL_W   = 3,
  parameter int SRC_BIT  = 0,
  parameter int CODE_LSB = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_i,
  input  logic [1:0]        mode_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [2:0]        clk_sel_o,
  output logic              src_reg_o,
  output logic [1:0]        code_o,
  output logic              rsvd_o
);

  localparam int CODE_W = 2;

  logic              src_q;
  logic [CODE_W-1:0] code_q;
  logic              rsvd_q;
  logic [CODE_W-1:0] wcode;
  clk_sel_e          sel_strap;
  clk_sel_e          sel_reg;

  assign wcode = wdata_i[CODE_LSB +: CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      code_q <= '0;
      rsvd_q <= 1'b0;
    end else if (we_i) begin
      src_q  <= wdata_i[SRC_BIT];
      code_q <= wcode;
      if (is_reserved(wcode)) rsvd_q <= 1'b1;
    end
  end

  always_comb begin
    sel_strap = strap_decode(strap_i);
    sel_reg   = reg_decode(code_q, mode_i);
    clk_sel_o = src_q ? sel_reg : sel_strap;
  end

  assign src_reg_o = src_q;
  assign code_o    = code_q;
  assign rsvd_o    = rsvd_q;

endmodule

// File: rtl/bist_phase.sv
module bist_phase (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic half_o
);

  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  // Second half of a pixel period: the sampling edge ends it.
  assign tick_o = ph_q;
  assign half_o = ph_q;

endmodule

// File: rtl/bist_session.sv
module bist_session #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             vld_i,
  input  logic             err_i,
  output logic             start_evt_o,
  output logic             end_evt_o,
  output logic             err_hit_o,
  output logic             cnt_zero_o,
  output logic             err_pix_o,
  output logic             vpix_o,
  output logic             vval_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    sat_inc = (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic             running_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_pix_q;
  logic             vpix_q;
  logic             vval_q;

  assign start_evt_o = tick_i &  run_i & ~running_q;
  assign end_evt_o   = tick_i & ~run_i &  running_q;
  assign err_hit_o   = tick_i &  run_i &  running_q & vld_i & err_i;
  assign cnt_zero_o  = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      err_pix_q <= 1'b0;
      vpix_q    <= 1'b0;
      vval_q    <= 1'b1;
    end else if (tick_i) begin
      err_pix_q <= err_hit_o;
      vpix_q    <= end_evt_o;
      if (end_evt_o) vval_q <= cnt_zero_o;
      if (start_evt_o) begin
        running_q <= 1'b1;
        cnt_q     <= '0;
      end else if (end_evt_o) begin
        running_q <= 1'b0;
      end else if (err_hit_o) begin
        cnt_q <= sat_inc(cnt_q);
      end
    end
  end

  assign err_pix_o = err_pix_q;
  assign vpix_o    = vpix_q;
  assign vval_o    = vval_q;
  assign cnt_o     = cnt_q;

endmodule

// File: rtl/bist_pass_drv.sv
module bist_pass_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic end_evt_i,
  input  logic cnt_zero_i,
  input  logic err_pix_i,
  input  logic vpix_i,
  input  logic vval_i,
  output logic pass_o
);

  logic pass_q;
  logic first_half_val;
  logic second_half_val;

  // The sampling edge loads the first-half level; the middle edge loads the second half.
  always_comb begin
    first_half_val  = end_evt_i ? cnt_zero_i : 1'b1;
    second_half_val = vpix_i ? vval_i : ~err_pix_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pass_q <= 1'b1;
    else if (tick_i) pass_q <= first_half_val;
    else             pass_q <= second_half_val;
  end

  assign pass_o = pass_q;

endmodule

// File: rtl/bist_ctrl_unit.sv
module bist_ctrl_unit #(
  parameter int CTRL_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              frame_vld_i,
  input  logic              frame_err_i,
  input  logic [1:0]        strap_i,
  input  logic [1:0]        mode_i,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic              pass_o,
  output logic [2:0]        clk_sel_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic              rsvd_o
);

  logic       tick;
  logic       half;
  logic       start_evt;
  logic       end_evt;
  logic       err_hit;
  logic       cnt_zero;
  logic       err_pix;
  logic       vpix;
  logic       vval;
  logic       cfg_src_reg;
  logic [1:0] cfg_code;

  bist_cfg #(.CTRL_W(CTRL_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_i   (strap_i),
    .mode_i    (mode_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .clk_sel_o (clk_sel_o),
    .src_reg_o (cfg_src_reg),
    .code_o    (cfg_code),
    .rsvd_o    (rsvd_o)
  );

  bist_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick),
    .half_o (half)
  );

  bist_session #(.CNT_W(CNT_W)) u_sess (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .run_i       (run_i),
    .vld_i       (frame_vld_i),
    .err_i       (frame_err_i),
    .start_evt_o (start_evt),
    .end_evt_o   (end_evt),
    .err_hit_o   (err_hit),
    .cnt_zero_o  (cnt_zero),
    .err_pix_o   (err_pix),
    .vpix_o      (vpix),
    .vval_o      (vval),
    .cnt_o       (err_cnt_o)
  );

  bist_pass_drv u_pass (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .end_evt_i  (end_evt),
    .cnt_zero_i (cnt_zero),
    .err_pix_i  (err_pix),
    .vpix_i     (vpix),
    .vval_i     (vval),
    .pass_o     (pass_o)
  );

endmodule

// File: rtl/bist_ctrl_unit_chk.sv
module bist_ctrl_unit_chk
  import bist_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             half,
  input logic             start_evt,
  input logic             end_evt,
  input logic             err_hit,
  input logic             cnt_zero,
  input logic             cfg_src_reg,
  input logic [1:0]       cfg_code,
  input logic             pass_o,
  input logic [2:0]       clk_sel_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             rsvd_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R5: an errored frame gives high then low in the next pixel period
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && err_hit) |=> pass_o ##1 !pass_o);

  // R5: a period with no errored frame and no session end keeps the pin high
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !err_hit && !end_evt) |=> pass_o ##1 pass_o);

  // R8: the verdict holds for both halves of the following period
  p_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && end_evt) |=> (pass_o == $past(cnt_zero)) ##1 (pass_o == $past(cnt_zero, 2)));

  // R6: the count moves by at most one per sampling edge
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start_evt) |=> (err_cnt_o == $past(err_cnt_o)) ||
                             (err_cnt_o == $past(err_cnt_o) + 1'b1));

  // R7: a saturated count stays saturated until a new session
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_o == CNT_MAX && !start_evt) |=> err_cnt_o == CNT_MAX);

  // R9: the count only changes on sampling edges, and a start clears it
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !half |=> $stable(err_cnt_o));
  p_start_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> err_cnt_o == '0);

  // R4: the reserved flag is sticky, and the reserved code maps to the pixel clock
  p_rsvd_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_o |=> rsvd_o);
  p_rsvd_pclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src_reg && cfg_code == 2'b11) |-> (clk_sel_o == SEL_PCLK) && rsvd_o);

endmodule

bind bist_ctrl_unit bist_ctrl_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .half        (half),
  .start_evt   (start_evt),
  .end_evt     (end_evt),
  .err_hit     (err_hit),
  .cnt_zero    (cnt_zero),
  .cfg_src_reg (cfg_src_reg),
  .cfg_code    (cfg_code),
  .pass_o      (pass_o),
  .clk_sel_o   (clk_sel_o),
  .err_cnt_o   (err_cnt_o),
  .rsvd_o      (rsvd_o)
);

// File: tb/bist_ctrl_unit_tb.sv
`timescale 1ns/1ps
module bist_ctrl_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_i, frame_vld_i, frame_err_i, reg_we_i;
  logic [1:0] strap_i, mode_i;
  logic [2:0] reg_wdata_i;
  logic       pass_o, rsvd_o;
  logic [2:0] clk_sel_o;
  logic [7:0] err_cnt_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the session
  bit m_running;
  int m_cnt;
  bit m_prev_h2;

  always #2 clk = ~clk;

  bist_ctrl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .frame_vld_i(frame_vld_i),
    .frame_err_i(frame_err_i), .strap_i(strap_i), .mode_i(mode_i),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .pass_o(pass_o),
    .clk_sel_o(clk_sel_o), .err_cnt_o(err_cnt_o), .rsvd_o(rsvd_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected selection: rate in half-MHz steps, then mapped to the code
  function automatic int rate_to_sel(input int hm);
    case (hm)
      200: return 1;
      150: return 2;
      100: return 3;
      75:  return 4;
      50:  return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_strap(input int s);
    if (s == 1) return rate_to_sel(100);
    if (s == 2) return rate_to_sel(50);
    return 0;
  endfunction

  function automatic int exp_reg(input int c, input int m);
    int base;
    base = (m == 0) ? 200 : (m == 1) ? 150 : 100;
    if (c == 1) return rate_to_sel(base);
    if (c == 2) return rate_to_sel(base / 2);
    return 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    run_i = 0; frame_vld_i = 0; frame_err_i = 0; reg_we_i = 0; reg_wdata_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_running = 0; m_cnt = 0; m_prev_h2 = 1;
  endtask

  task automatic reg_write(input logic [2:0] d);
    reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  // one pixel period; caller stands at a negedge just before the first edge of the pair
  task automatic pix(input bit r, input bit v, input bit e, input string cnt_tag);
    bit start, stop, errf, vval, h1, h2;
    run_i = r; frame_vld_i = v; frame_err_i = e;
    start = r && !m_running;
    stop  = !r && m_running;
    errf  = m_running && r && v && e;
    vval  = (m_cnt == 0);
    if (start) begin m_running = 1; m_cnt = 0; end
    else if (stop) m_running = 0;
    else if (errf && m_cnt < 255) m_cnt++;
    h1 = stop ? vval : 1'b1;
    h2 = stop ? vval : !errf;
    @(negedge clk);
    check("R5 second half", pass_o, m_prev_h2);
    @(negedge clk);
    check(stop ? "R8 verdict first half" : "R5 first half", pass_o, h1);
    check(cnt_tag, err_cnt_o, m_cnt);
    m_prev_h2 = h2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    strap_i = 2'b01; mode_i = 2'b00;
    do_reset();
    // R1 reset state
    check("R1 pass", pass_o, 1);
    check("R1 count", err_cnt_o, 0);
    check("R1 rsvd", rsvd_o, 0);
    check("R1 strap source", clk_sel_o, exp_strap(1));

    // R2 strap sweep over every mode
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        strap_i = 2'(s); mode_i = 2'(m);
        #0.5;
        check("R2 strap decode", clk_sel_o, exp_strap(s));
      end
    end

    // R3, R4 register sweep
    strap_i = 2'b10;
    for (int c = 0; c < 4; c++) begin
      reg_write({2'(c), 1'b1});
      for (int m = 0; m < 4; m++) begin
        mode_i = 2'(m);
        #0.5;
        if (c == 3) check("R4 reserved as pclk", clk_sel_o, 0);
        else        check("R3 register decode", clk_sel_o, exp_reg(c, m));
      end
      check("R4 sticky flag", rsvd_o, (c == 3) ? 1 : 0);
    end
    reg_write(3'b010);
    check("R3 back to straps", clk_sel_o, exp_strap(2));
    check("R4 flag kept", rsvd_o, 1);

    // sessions, freshly aligned to the pixel phase
    do_reset();
    pix(0, 1, 1, "R6 idle ignored");
    pix(0, 1, 1, "R6 idle ignored");
    pix(1, 1, 1, "R6 start frame ignored");
    pix(1, 1, 0, "R6 clean frame");
    pix(1, 0, 1, "R6 invalid frame");
    pix(1, 1, 1, "R6 errored frame");
    pix(1, 1, 1, "R6 back to back");
    pix(1, 1, 0, "R6 clean frame");
    pix(0, 0, 0, "R9 kept at end");
    pix(0, 1, 1, "R9 kept after end");
    pix(0, 0, 0, "R9 kept after end");
    pix(1, 0, 0, "R9 cleared at start");
    for (int i = 0; i < 3; i++) pix(1, 1, 0, "R6 clean run");
    pix(0, 0, 0, "R8 clean verdict");
    pix(0, 0, 0, "R9 idle");
    pix(0, 0, 0, "R9 idle");

    // R7 saturation
    pix(1, 0, 0, "R9 cleared at start");
    for (int i = 0; i < 262; i++) pix(1, 1, 1, "R7 saturating count");
    pix(0, 0, 0, "R7 saturated at end");
    pix(0, 0, 0, "R7 saturated held");

    // mixed patterns across several sessions
    for (int i = 0; i < 120; i++)
      pix((i % 17) != 16, (i % 3) != 0, (i % 2) == 1, "R6 mixed pattern");
    pix(0, 0, 0, "R8 mixed end");
    pix(0, 0, 0, "R9 idle");
    @(negedge clk);
    check("R5 final second half", pass_o, m_prev_h2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule